// File: doc/BRIEF.md
# Chainable Four-Channel Down-Counting Timer Group

This block holds a set of down-counting timers that share one prescaled clock and sit behind a plain register bus. Reads are combinational from the address and writes take effect at the next clock edge. Each timer reloads from its base value and inverts a toggle flag every time it counts through zero. It also latches an interrupt, which drives an active-low level output until software acknowledges it. This repeats on every period until the timer is inhibited again.

A group control word selects the prescale ratio. It can also link neighbouring timers into one wider counter. In a link the lower timer counts prescaled ticks over its full 32-bit range. The upper timer counts only when the lower one expires, and only the upper timer raises the link's interrupt. A per-link rollover option makes the lower timer restart from all ones instead of from its base value.

Software allocates a timer as follows. It writes the base register with the inhibit bit set, which also preloads the count. It then writes the base again with the inhibit bit clear, which starts counting. Each interrupt is cleared through the acknowledge word.

Top module: `chain_tmr_group`

## Requirements
- R1: After reset every base register reads 0x8000_0000 (inhibited), every count register reads 0, the control word reads 0 and all irq_n outputs are high.
- R2: A prescaled tick occurs once every 8 << S clocks, where S is control bits 9:8 (so 00 gives 8, 01 gives 16, 10 gives 32 and 11 gives 64). A lone timer with base B therefore interrupts every (B+1)·8<<S clocks.
- R3: Base-register bit 31 inhibits counting. A base write with bit 31 set also loads the count from data bits 30:0 and clears the toggle. A base write with bit 31 clear starts counting from the current count.
- R4: On each tick a running timer decrements. When its count is already 0, it instead reloads from base bits 30:0 and inverts the toggle flag, which reads back as bit 31 of the count register.
- R5: Each expiry of a non-lower timer sets its pending flag and drives irq_n[n] low. The flag stays set until a write to the status word with bit n set clears it; a new expiry in the same cycle wins. The status word reads the pending flags in bits 3:0.
- R6: Writes to a count register have no effect.
- R7: Control bit k (k = 0..2) links timer k (lower) with timer k+1 (upper). The lower timer counts ticks over 32 bits and reads back all 32 count bits. The upper timer advances only on lower-timer expiry. The lower timer's inhibit follows the upper timer's base bit 31.
- R8: A timer acting as the lower half of a link never sets its pending flag, so its irq_n output stays high.
- R9: Control bit 24+k enables rollover on link k. On expiry the lower timer then reloads 0xFFFF_FFFF instead of its base value.
- R10: Timer n occupies the 64-byte window at n·0x40, with the count at +0x00, base at +0x10, vector/priority storage at +0x20 and destination storage at +0x30. The control word is at 0x100 and the status word at 0x110. Accesses whose address bits 3:0 are not zero, and any other address, read 0 and are ignored on write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 9 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_n | output | 4 | Active-low level interrupt, one per timer |

## Verification
A wrong count or toggle shows on the next read of that timer's count register. It also shows as an interrupt that arrives early or late by whole tick periods, so the error is visible within one period. A wrong prescaler phase or ratio skews every period by multiples of eight clocks. A bad link decode shows either as the lower timer raising its own interrupt or as the upper half advancing on plain ticks. Both are visible within a few lower-timer periods. A pending flag that is lost or stuck shows on irq_n in the cycle after the expiry or the acknowledge.

// File: rtl/chain_tmr_pkg.sv
package chain_tmr_pkg;
   localparam int REG_W       = 32;
   localparam int WIN_LSB     = 6;
   localparam int INHIBIT_BIT = 31;
   localparam int PSEL_LSB    = 8;
   localparam int ROVR_LSB    = 24;

   typedef enum logic [1:0] {
      SEL_COUNT  = 2'd0,
      SEL_BASE   = 2'd1,
      SEL_VECPRI = 2'd2,
      SEL_DEST   = 2'd3
   } tmr_sel_e;

   typedef enum logic [1:0] {
      GSEL_CTRL = 2'd0,
      GSEL_STAT = 2'd1,
      GSEL_RSV2 = 2'd2,
      GSEL_RSV3 = 2'd3
   } grp_sel_e;
endpackage

// File: rtl/chain_tmr_prescale.sv
module chain_tmr_prescale #(
   parameter  int MIN_DIV_LOG2 = 3,
   localparam int PCW          = MIN_DIV_LOG2 + 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] psel_i,
   output logic       tick_o
);
   logic [PCW-1:0] cnt_q;
   logic [PCW:0]   div_full;
   logic [PCW-1:0] div_m1;

   assign div_full = (PCW+1)'(1) << (MIN_DIV_LOG2 + int'(psel_i));
   assign div_m1   = PCW'(div_full - (PCW+1)'(1));
   // a shrinking ratio may leave the counter above the new limit: fire at once
   assign tick_o   = (cnt_q >= div_m1);

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt_q <= '0;
      else if (tick_o) cnt_q <= '0;
      else             cnt_q <= cnt_q + PCW'(1);
   end

   // R2
   tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tick_o) |=> !tick_o);
endmodule

// File: rtl/chain_tmr_chan.sv
module chain_tmr_chan
   import chain_tmr_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             inhibit_i,
   input  logic             lower_i,
   input  logic             rollover_i,
   input  logic [REG_W-1:0] base_i,
   input  logic             load_i,
   input  logic [REG_W-2:0] load_val_i,
   output logic [REG_W-1:0] cnt_o,
   output logic             tog_o,
   output logic             zero_o
);
   logic [REG_W-1:0] cnt_q;
   logic             tog_q;
   logic             run;
   logic [REG_W-1:0] reload;

   assign run    = tick_i & ~inhibit_i;
   assign zero_o = lower_i ? (cnt_q == '0) : (cnt_q[REG_W-2:0] == '0);

   always_comb begin
      if (!lower_i)        reload = {1'b0, base_i[REG_W-2:0]};
      else if (rollover_i) reload = '1;
      else                 reload = base_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         tog_q <= 1'b0;
      end else if (load_i) begin
         cnt_q <= {1'b0, load_val_i};
         tog_q <= 1'b0;
      end else if (run) begin
         if (zero_o) begin
            cnt_q <= reload;
            tog_q <= ~tog_q;
         end else begin
            cnt_q <= cnt_q - REG_W'(1);
         end
      end
   end

   assign cnt_o = cnt_q;
   assign tog_o = tog_q;

   // R3
   inhibit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inhibit_i && !load_i) |=> $stable(cnt_q));
   // R3
   load_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (!tog_q && !cnt_q[REG_W-1]));
   // R4
   tog_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!(run && zero_o) && !load_i) |=> $stable(tog_q));
   // R4
   tog_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && zero_o && !load_i) |=> (tog_q != $past(tog_q)));
endmodule

// File: rtl/chain_tmr_group.sv
module chain_tmr_group
   import chain_tmr_pkg::*;
#(
   parameter  int NTMR         = 4,
   parameter  int MIN_DIV_LOG2 = 3,
   localparam int ADDR_W       = $clog2((NTMR + 1) * 64)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [REG_W-1:0]  bus_wdata,
   output logic [REG_W-1:0]  bus_rdata,
   output logic [NTMR-1:0]   irq_n
);
   localparam int NCH   = NTMR - 1;
   localparam int WIN_W = ADDR_W - WIN_LSB;

   if (NTMR < 2 || NTMR > 8) begin : g_bad_ntmr
      $error("chain_tmr_group: NTMR must lie in 2..8");
   end
   if (MIN_DIV_LOG2 < 1 || MIN_DIV_LOG2 > 8) begin : g_bad_div
      $error("chain_tmr_group: MIN_DIV_LOG2 must lie in 1..8");
   end

   // address decode
   logic [WIN_W-1:0] win;
   logic [1:0]       sel;
   logic             aligned;
   logic             grp_hit;

   assign win     = bus_addr[ADDR_W-1:WIN_LSB];
   assign sel     = bus_addr[WIN_LSB-1:WIN_LSB-2];
   assign aligned = (bus_addr[WIN_LSB-3:0] == '0);
   assign grp_hit = aligned && (win == WIN_W'(NTMR));

   // group state
   logic [1:0]       psel_q;
   logic [NCH-1:0]   casc_q;
   logic [NCH-1:0]   rovr_q;
   logic [NTMR-1:0]  pend_q;
   logic             ctrl_wr;
   logic [NTMR-1:0]  ack_mask;
   logic             tick;

   assign ctrl_wr  = bus_wr && grp_hit && (grp_sel_e'(sel) == GSEL_CTRL);
   assign ack_mask = (bus_wr && grp_hit && (grp_sel_e'(sel) == GSEL_STAT))
                     ? bus_wdata[NTMR-1:0] : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         psel_q <= '0;
         casc_q <= '0;
         rovr_q <= '0;
      end else if (ctrl_wr) begin
         psel_q <= bus_wdata[PSEL_LSB +: 2];
         casc_q <= bus_wdata[NCH-1:0];
         rovr_q <= bus_wdata[ROVR_LSB +: NCH];
      end
   end

   chain_tmr_prescale #(.MIN_DIV_LOG2(MIN_DIV_LOG2)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .psel_i (psel_q),
      .tick_o (tick)
   );

   // per-timer state and linking
   logic [REG_W-1:0] base_q [NTMR];
   logic [REG_W-1:0] vp_q   [NTMR];
   logic [REG_W-1:0] dst_q  [NTMR];
   logic [REG_W-1:0] cnt_v  [NTMR];
   logic [NTMR-1:0]  tog_v;
   logic [NTMR-1:0]  zero_v;
   logic [NTMR-1:0]  lower_v;
   logic [NTMR-1:0]  inh_v;
   logic [NTMR-1:0]  tin_v;
   logic [NTMR-1:0]  exp_v;

   assign lower_v = {1'b0, casc_q};

   // a lower half inherits the inhibit of the timer above it
   always_comb begin
      logic acc;
      acc = base_q[NTMR-1][INHIBIT_BIT];
      inh_v[NTMR-1] = acc;
      for (int n = NTMR - 2; n >= 0; n--) begin
         acc      = casc_q[n] ? acc : base_q[n][INHIBIT_BIT];
         inh_v[n] = acc;
      end
   end

   // tick source ripples upward through linked neighbours
   always_comb begin
      tin_v[0] = tick;
      exp_v[0] = tick & ~inh_v[0] & zero_v[0];
      for (int n = 1; n < NTMR; n++) begin
         tin_v[n] = casc_q[n-1] ? exp_v[n-1] : tick;
         exp_v[n] = tin_v[n] & ~inh_v[n] & zero_v[n];
      end
   end

   for (genvar n = 0; n < NTMR; n++) begin : g_ch
      logic base_wr;
      logic tmr_hit;
      logic rov;

      assign tmr_hit = aligned && bus_wr && (win == WIN_W'(n));
      assign base_wr = tmr_hit && (tmr_sel_e'(sel) == SEL_BASE);

      if (n < NCH) begin : g_rov
         assign rov = rovr_q[n];
      end else begin : g_norov
         assign rov = 1'b0;
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            base_q[n] <= {1'b1, {(REG_W-1){1'b0}}};
            vp_q[n]   <= '0;
            dst_q[n]  <= '0;
         end else begin
            if (base_wr) base_q[n] <= bus_wdata;
            if (tmr_hit && (tmr_sel_e'(sel) == SEL_VECPRI)) vp_q[n]  <= bus_wdata;
            if (tmr_hit && (tmr_sel_e'(sel) == SEL_DEST))   dst_q[n] <= bus_wdata;
         end
      end

      chain_tmr_chan u_chan (
         .clk        (clk),
         .rst_n      (rst_n),
         .tick_i     (tin_v[n]),
         .inhibit_i  (inh_v[n]),
         .lower_i    (lower_v[n]),
         .rollover_i (rov),
         .base_i     (base_q[n]),
         .load_i     (base_wr && bus_wdata[INHIBIT_BIT]),
         .load_val_i (bus_wdata[REG_W-2:0]),
         .cnt_o      (cnt_v[n]),
         .tog_o      (tog_v[n]),
         .zero_o     (zero_v[n])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~ack_mask) | (exp_v & ~lower_v);
   end

   assign irq_n = ~pend_q;

   // read path
   logic [REG_W-1:0] ctrl_word;

   always_comb begin
      ctrl_word = '0;
      ctrl_word[PSEL_LSB +: 2]   = psel_q;
      ctrl_word[NCH-1:0]         = casc_q;
      ctrl_word[ROVR_LSB +: NCH] = rovr_q;
   end

   always_comb begin
      bus_rdata = '0;
      if (grp_hit) begin
         case (grp_sel_e'(sel))
            GSEL_CTRL: bus_rdata = ctrl_word;
            GSEL_STAT: bus_rdata[NTMR-1:0] = pend_q;
            default:   bus_rdata = '0;
         endcase
      end else if (aligned) begin
         for (int n = 0; n < NTMR; n++) begin
            if (win == WIN_W'(n)) begin
               case (tmr_sel_e'(sel))
                  SEL_COUNT:  bus_rdata = lower_v[n] ? cnt_v[n]
                                          : {tog_v[n], cnt_v[n][REG_W-2:0]};
                  SEL_BASE:   bus_rdata = base_q[n];
                  SEL_VECPRI: bus_rdata = vp_q[n];
                  default:    bus_rdata = dst_q[n];
               endcase
            end
         end
      end
   end

   for (genvar n = 0; n < NTMR; n++) begin : g_chk
      // R5
      pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (pend_q[n] && !ack_mask[n]) |=> pend_q[n]);
      // R8
      lower_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (lower_v[n] && !pend_q[n]) |=> !pend_q[n]);
   end
endmodule

// File: tb/chain_tmr_group_tb.sv
`timescale 1ns/1ps
module chain_tmr_group_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [8:0]  addr = '0;
   logic        wr = 1'b0;
   logic [31:0] wdata = '0;
   wire  [31:0] rdata;
   wire  [3:0]  irq_n;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   chain_tmr_group u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr),
      .bus_wdata(wdata), .bus_rdata(rdata), .irq_n(irq_n)
   );

   // reference model, written from the requirements
   bit [31:0] m_cnt [4];
   bit [31:0] m_base [4];
   bit [31:0] m_vp [4];
   bit [31:0] m_dst [4];
   bit [3:0]  m_tog, m_pend;
   bit [1:0]  m_psel;
   bit [2:0]  m_casc, m_rovr;
   bit [5:0]  m_pc;

   always @(posedge clk) begin : mdl
      bit tick, acc, al, ldh;
      bit [3:0] inh, low, tin, ex, zz, ack;
      bit [6:0] dv;
      bit [5:0] dm1;
      bit [2:0] w;
      bit [1:0] s;
      if (!rst_n) begin
         for (int n = 0; n < 4; n++) begin
            m_cnt[n] = 0; m_base[n] = 32'h8000_0000; m_vp[n] = 0; m_dst[n] = 0;
         end
         m_tog = 0; m_pend = 0; m_psel = 0; m_casc = 0; m_rovr = 0; m_pc = 0;
      end else begin
         dv   = 7'd1 << (3 + m_psel);
         dm1  = 6'(dv - 7'd1);
         tick = (m_pc >= dm1);
         low  = {1'b0, m_casc};
         acc  = m_base[3][31];
         inh[3] = acc;
         for (int n = 2; n >= 0; n--) begin
            acc = m_casc[n] ? acc : m_base[n][31];
            inh[n] = acc;
         end
         for (int n = 0; n < 4; n++) begin
            zz[n] = low[n] ? (m_cnt[n] == 0) : (m_cnt[n][30:0] == 0);
            if (n == 0) tin[n] = tick;
            else        tin[n] = m_casc[n-1] ? ex[n-1] : tick;
            ex[n] = tin[n] & ~inh[n] & zz[n];
         end
         m_pc = tick ? 6'd0 : m_pc + 6'd1;
         al = (addr[3:0] == 0); w = addr[8:6]; s = addr[5:4];
         ack = (wr && al && w == 3'd4 && s == 2'd1) ? wdata[3:0] : 4'h0;
         for (int n = 0; n < 4; n++) begin
            ldh = wr && al && (w == 3'(n)) && (s == 2'd1);
            if (ldh && wdata[31]) begin
               m_cnt[n] = {1'b0, wdata[30:0]}; m_tog[n] = 1'b0;
            end else if (tin[n] && !inh[n]) begin
               if (zz[n]) begin
                  if (!low[n])             m_cnt[n] = {1'b0, m_base[n][30:0]};
                  else if (m_rovr[n])      m_cnt[n] = 32'hFFFF_FFFF;
                  else                     m_cnt[n] = m_base[n];
                  m_tog[n] = ~m_tog[n];
               end else begin
                  m_cnt[n] = m_cnt[n] - 1;
               end
            end
            if (wr && al && w == 3'(n)) begin
               if (s == 2'd1) m_base[n] = wdata;
               if (s == 2'd2) m_vp[n]   = wdata;
               if (s == 2'd3) m_dst[n]  = wdata;
            end
         end
         m_pend = (m_pend & ~ack) | (ex & ~low);
         if (wr && al && w == 3'd4 && s == 2'd0) begin
            m_psel = wdata[9:8]; m_casc = wdata[2:0]; m_rovr = wdata[26:24];
         end
      end
   end

   function automatic bit [31:0] m_read(bit [8:0] a);
      bit [2:0] w;
      bit [1:0] s;
      w = a[8:6]; s = a[5:4];
      if (a[3:0] != 0) return 32'h0;
      if (w == 3'd4) begin
         if (s == 2'd0) return {5'b0, m_rovr, 14'b0, m_psel, 5'b0, m_casc};
         if (s == 2'd1) return {28'b0, m_pend};
         return 32'h0;
      end
      if (w < 3'd4) begin
         case (s)
            2'd0: return (w < 3'd3 && m_casc[w]) ? m_cnt[w] : {m_tog[w], m_cnt[w][30:0]};
            2'd1: return m_base[w];
            2'd2: return m_vp[w];
            default: return m_dst[w];
         endcase
      end
      return 32'h0;
   endfunction

   function automatic string tag_of(bit [8:0] a);
      if (a[3:0] != 0 || a[8:6] > 3'd4) return "R10 unmapped";
      if (a[8:6] == 3'd4) return (a[5:4] == 2'd1) ? "R5 status" : "R2 control";
      case (a[5:4])
         2'd0: return "R4 count";
         2'd1: return "R3 base";
         default: return "R10 storage";
      endcase
   endfunction

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic step(input bit w, input bit [8:0] a, input bit [31:0] d, input string tag);
      @(negedge clk);
      wr = w; addr = a; wdata = d;
      #1;
      check({28'b0, irq_n}, {28'b0, ~m_pend}, "R5 irq_n");
      if (!w) check(rdata, m_read(a), tag);
   endtask

   task automatic rd_lit(input bit [8:0] a, input bit [31:0] exp, input string tag);
      step(1'b0, a, 32'h0, tag);
      check(rdata, exp, tag);
   endtask

   task automatic idle(input int n, input bit [8:0] a);
      for (int i = 0; i < n; i++) step(1'b0, a, 32'h0, tag_of(a));
   endtask

   initial begin : watchdog
      #(200000 * 5);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog R1..all act=running exp=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin : main
      int k;
      bit [31:0] v1;
      bit [8:0]  ra;
      int r;
      void'($urandom(32'd2024));
      repeat (4) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state
      for (int n = 0; n < 4; n++) begin
         rd_lit(9'(n * 64 + 16), 32'h8000_0000, "R1 base");
         rd_lit(9'(n * 64), 32'h0, "R1 count");
      end
      rd_lit(9'h100, 32'h0, "R1 control");
      check({28'b0, irq_n}, 32'hF, "R1 irq_n");

      // R6 count writes ignored
      step(1'b1, 9'h0C0, 32'h1234_5678, "R6");
      rd_lit(9'h0C0, 32'h0, "R6 count after write");

      // R10 storage and map
      step(1'b1, 9'h060, 32'hA5A5_0001, "R10");
      step(1'b1, 9'h0F0, 32'h0000_0F0F, "R10");
      rd_lit(9'h060, 32'hA5A5_0001, "R10 vecpri");
      rd_lit(9'h0F0, 32'h0000_0F0F, "R10 dest");
      rd_lit(9'h064, 32'h0, "R10 unaligned");
      rd_lit(9'h140, 32'h0, "R10 unmapped");

      // R3 preload while inhibited, then start
      step(1'b1, 9'h090, 32'h8000_0005, "R3");
      rd_lit(9'h080, 32'h5, "R3 preload");
      idle(20, 9'h080);
      rd_lit(9'h080, 32'h5, "R3 inhibit holds");
      step(1'b1, 9'h090, 32'h0000_0005, "R3");
      k = 0;
      while (k < 200 && irq_n[2]) begin
         step(1'b0, 9'h080, 32'h0, "R4 count");
         k++;
      end
      check(32'(k >= 38 && k <= 52), 32'h1, "R4 first period");
      check({31'b0, rdata[31]}, 32'h1, "R4 toggle set");
      step(1'b1, 9'h110, 32'h4, "R5 ack");
      step(1'b0, 9'h110, 32'h0, "R5 status");
      check({31'b0, irq_n[2]}, 32'h1, "R5 ack releases irq");
      step(1'b1, 9'h090, 32'h8000_0000, "R3 stop");
      step(1'b1, 9'h110, 32'hF, "R5 ack");

      // R2 period at divide-by-64
      step(1'b1, 9'h100, 32'h0000_0300, "R2");
      step(1'b1, 9'h0D0, 32'h8000_0001, "R2");
      step(1'b1, 9'h0D0, 32'h0000_0001, "R2");
      k = 0;
      while (k < 400 && irq_n[3]) begin step(1'b0, 9'h0C0, 32'h0, "R4 count"); k++; end
      step(1'b1, 9'h110, 32'h8, "R5 ack");
      k = 1;
      while (k < 400) begin
         step(1'b0, 9'h0C0, 32'h0, "R4 count");
         k++;
         if (!irq_n[3]) break;
      end
      check(32'(k), 32'd128, "R2 period div64");
      step(1'b1, 9'h0D0, 32'h8000_0000, "R3 stop");
      step(1'b1, 9'h110, 32'hF, "R5 ack");
      step(1'b1, 9'h100, 32'h0, "R2");

      // R7/R8 link timers 0 and 1
      step(1'b1, 9'h100, 32'h0000_0001, "R7");
      step(1'b1, 9'h010, 32'h8000_0003, "R7");
      step(1'b1, 9'h010, 32'h0000_0003, "R7");
      step(1'b1, 9'h050, 32'h8000_0002, "R7");
      step(1'b1, 9'h050, 32'h0000_0002, "R7");
      k = 0;
      while (k < 300 && irq_n[1]) begin
         step(1'b0, 9'h000, 32'h0, "R7 lower count");
         check({31'b0, irq_n[0]}, 32'h1, "R8 lower irq quiet");
         k++;
      end
      check(32'(k >= 86 && k <= 100), 32'h1, "R7 linked period");
      check({31'b0, irq_n[0]}, 32'h1, "R8 lower irq quiet");
      step(1'b1, 9'h050, 32'h8000_0000, "R7 stop upper");
      step(1'b0, 9'h000, 32'h0, "R7 lower count");
      v1 = rdata;
      idle(24, 9'h000);
      rd_lit(9'h000, v1, "R7 lower follows upper inhibit");

      // R9 rollover on link 0
      step(1'b1, 9'h110, 32'hF, "R5 ack");
      step(1'b1, 9'h100, 32'h0100_0001, "R9");
      step(1'b1, 9'h050, 32'h8000_0005, "R9");
      step(1'b1, 9'h050, 32'h0000_0005, "R9");
      k = 0;
      while (k < 80) begin
         step(1'b0, 9'h000, 32'h0, "R7 lower count");
         k++;
         if (rdata[31]) break;
      end
      check(32'(rdata >= 32'hFFFF_FF00), 32'h1, "R9 lower reloads all ones");
      for (int n = 0; n < 4; n++) step(1'b1, 9'(n * 64 + 16), 32'h8000_0000, "R3 stop");
      step(1'b1, 9'h100, 32'h0, "R7");
      step(1'b1, 9'h110, 32'hF, "R5 ack");

      // constrained random mix
      for (int i = 0; i < 3000; i++) begin
         r = $urandom_range(0, 99);
         k = $urandom_range(0, 3);
         if (r < 6) begin
            step(1'b1, 9'(k * 64 + 16),
                 {($urandom_range(0, 3) == 0), 31'($urandom_range(0, 24))}, "R3");
         end else if (r < 8) begin
            v1 = 32'h0;
            v1[9:8] = 2'($urandom_range(0, 3));
            v1[2:0] = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 3) == 0) v1[26:24] = 3'($urandom_range(0, 7));
            step(1'b1, 9'h100, v1, "R7");
         end else if (r < 14) begin
            step(1'b1, 9'h110, 32'($urandom_range(0, 15)), "R5");
         end else if (r < 18) begin
            step(1'b1, 9'(k * 64 + 32 + 16 * $urandom_range(0, 1)), $urandom, "R10");
         end else if (r < 20) begin
            step(1'b1, 9'(k * 64), $urandom, "R6");
         end else begin
            ra = 9'($urandom_range(0, 4) * 64 + $urandom_range(0, 3) * 16);
            if ($urandom_range(0, 19) == 0) ra = 9'($urandom_range(0, 511));
            step(1'b0, ra, 32'h0, tag_of(ra));
         end
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule